// File: doc/BRIEF.md
# Successive-Approximation Controller for a Pulse-Stream DAC

This block runs an analog-to-digital conversion by binary search. It holds a trial code that feeds an on-chip stochastic pulse-stream DAC. Off chip, a low-pass filter averages that pulse stream into a voltage, and an analog comparator sets it against the input to be measured. The comparator's one-bit verdict comes back into the controller, which decides one result bit per trial, most significant bit first.

The filter needs a long time to settle after the trial code changes. A conversion at eight bits with a 40 MHz clock and a first-order filter needs on the order of 2.27 ms in the worst case. So every bit trial lasts a settle interval that the caller supplies on a port. The port is read again each time a trial begins. A start pulse begins a conversion. When the last bit is known, a one-cycle done pulse is raised and the result is held.

Top module: `sar_stoch_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, done_o, result_o and dac_code_o are all zero.
- R2: A start_i seen high at a clock edge while the controller is idle makes dac_code_o equal to the code with only the top bit set (512 for 10 bits), from that edge on.
- R3: Each bit trial lasts settle_i+1 clock edges, with settle_i read when the trial begins. done_o rises at the edge that is RES_W*(settle_i+1) edges after the edge that accepted start_i.
- R4: At the last edge of a trial, the bit under test stays 1 if the synchronized comparator reads 1 (input at or above the DAC level) and is cleared if it reads 0. The next lower bit is set to 1 at that same edge.
- R5: cmp_i passes through a two-flop synchronizer before any decision uses it. A settle_i of 2 is the smallest value that still gives exact results with an ideal comparator.
- R6: With an ideal comparator, the final result_o equals the input code for every code in the range, including 0 and full scale.
- R7: start_i is ignored while a conversion runs. Timing, result and the count of done pulses are the same as if no extra pulse had come.
- R8: done_o is high for exactly one cycle per conversion. result_o takes the final code at the same edge.
- R9: Between done pulses, result_o does not change. After a conversion, dac_code_o keeps the final code even when the comparator input moves.
- R10: Inside a trial, dac_code_o changes only at the trial's last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion (ignored when busy) |
| settle_i | input | CNT_W | Extra wait edges per bit trial |
| cmp_i | input | 1 | External comparator: 1 when input is at or above the DAC level |
| dac_code_o | output | RES_W | Trial code to the pulse-stream DAC |
| result_o | output | RES_W | Last completed conversion result |
| done_o | output | 1 | One-cycle pulse when a conversion ends |

## Verification
Some properties are checked on every cycle. These are the done pulse width, that result_o holds between pulses, the loading of the top-bit trial on start, the per-cycle countdown of the settle timer, that extra starts are ignored while busy, and that the trial code stays stable inside a trial. Other behaviour can only be shown by the scenarios, with a comparator model that is ideal but delayed. These are that the binary search lands on the right code, that the edge count from start to done matches the settle value, and that a two-flop synchronizer still works at the minimum settle of 2.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_TRIAL = 1'b1
  } sar_state_t;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_settle_tmr.sv
module sar_settle_tmr #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             decide_i,
  input  logic             keep_i,
  output logic [RES_W-1:0] code_o,
  output logic [RES_W-1:0] resolved_o,
  output logic             last_o
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] ptr_q;

  always_comb begin
    resolved_o = keep_i ? code_q : (code_q & ~ptr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      ptr_q  <= '0;
    end else if (load_i) begin
      code_q <= TOP_BIT;
      ptr_q  <= TOP_BIT;
    end else if (decide_i) begin
      code_q <= resolved_o | (ptr_q >> 1);
      ptr_q  <= ptr_q >> 1;
    end
  end

  assign code_o = code_q;
  assign last_o = ptr_q[0];
endmodule

// File: rtl/sar_stoch_ctrl.sv
module sar_stoch_ctrl
  import sar_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int CNT_W     = 24,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);
  sar_state_t       state_q;
  logic             busy;
  logic             accept;
  logic             decide;
  logic             last_bit;
  logic             cmp_s;
  logic             tmr_zero;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_cnt;
  logic [RES_W-1:0] resolved;
  logic [RES_W-1:0] result_q;
  logic             done_q;

  assign busy     = (state_q == ST_TRIAL);
  assign accept   = !busy && start_i;
  assign decide   = busy && tmr_zero;
  assign tmr_load = accept || (decide && !last_bit);

  sar_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cmp_i),
    .q_o (cmp_s)
  );

  sar_settle_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (settle_i),
    .cnt_o      (tmr_cnt),
    .zero_o     (tmr_zero)
  );

  sar_bit_reg #(.RES_W(RES_W)) u_bits (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .decide_i   (decide),
    .keep_i     (cmp_s),
    .code_o     (dac_code_o),
    .resolved_o (resolved),
    .last_o     (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_TRIAL;
        ST_TRIAL: begin
          if (decide && last_bit) begin
            state_q  <= ST_IDLE;
            result_q <= resolved;
            done_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int RES_W = 10,
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [CNT_W-1:0] settle_i,
  input logic             busy,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic [RES_W-1:0] dac_code_o,
  input logic [RES_W-1:0] result_o,
  input logic             done_o
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy && $past(busy))); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o)); // R9
  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_i) |=> (busy && dac_code_o == TOP_BIT && tmr_cnt == $past(settle_i))); // R2
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && tmr_cnt != '0) |=> (tmr_cnt == $past(tmr_cnt) - 1'b1)); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i && tmr_cnt != '0) |=> busy); // R7
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && tmr_cnt != '0) |=> $stable(dac_code_o)); // R10
endmodule

bind sar_stoch_ctrl sar_ctrl_chk #(.RES_W(RES_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .settle_i   (settle_i),
  .busy       (busy),
  .tmr_cnt    (tmr_cnt),
  .dac_code_o (dac_code_o),
  .result_o   (result_o),
  .done_o     (done_o)
);

// File: tb/tb_sar_stoch_ctrl.sv
module tb_sar_stoch_ctrl;
  localparam int W = 10;
  localparam int C = 24;
  localparam logic [W-1:0] TOP = 10'd512;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [C-1:0] settle_i = '0;
  logic         cmp_i;
  logic [W-1:0] dac_code_o, result_o;
  logic         done_o;
  logic [W-1:0] target = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int dones = 0;
  logic prev_done = 1'b0;

  typedef struct {
    logic [W-1:0] tgt;
    int           t0;
    int           lat;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ideal filter plus comparator
  assign cmp_i = (target >= dac_code_o);

  sar_stoch_ctrl #(.RES_W(W), .CNT_W(C)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .settle_i(settle_i),
    .cmp_i(cmp_i), .dac_code_o(dac_code_o), .result_o(result_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected items on each done pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) begin
        if (prev_done) chk("R8 done width", 1, 0);
        if (q.size() == 0) chk("R7 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk("R6 result", int'(result_o), int'(e.tgt));
          // start raised before edge t0+1; done visible after edge t0+1+lat
          chk("R3 latency", cyc - e.t0, e.lat + 1);
        end
        dones++;
      end
      prev_done = done_o;
    end
  end

  task automatic convert(input logic [W-1:0] tgt, input int settle, input bit extra);
    exp_t e;
    int   d0;
    logic [W-1:0] r;
    logic [W-1:0] second;
    @(negedge clk);
    target   = tgt;
    settle_i = C'(settle);
    start_i  = 1'b1;
    e.tgt = tgt; e.t0 = cyc; e.lat = W * (settle + 1);
    q.push_back(e);
    d0 = dones;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 top-bit trial", int'(dac_code_o), int'(TOP));
    for (int i = 0; i < settle; i++) begin
      if (extra && i == 0) start_i = 1'b1;
      if (extra && i == 1) start_i = 1'b0;
      @(negedge clk);
      chk("R10 code stable in trial", int'(dac_code_o), int'(TOP));
    end
    start_i = 1'b0;
    @(negedge clk);
    second = ((tgt >= TOP) ? TOP : 10'd0) | 10'd256;
    chk(settle == 2 ? "R4 R5 second trial" : "R4 second trial", int'(dac_code_o), int'(second));
    for (int i = 0; i < 4000 && dones == d0; i++) @(negedge clk);
    chk("R7 one done per start", dones - d0, 1);
    r = result_o;
    target = ~tgt;
    repeat (3 * (settle + 1)) @(negedge clk);
    chk("R9 result held", int'(result_o), int'(r));
    chk("R9 code held", int'(dac_code_o), int'(r));
    chk("R7 no extra done", dones - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done_o), 0);
    chk("R1 result in reset", int'(result_o), 0);
    chk("R1 code in reset", int'(dac_code_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 code after reset", int'(dac_code_o), 0);
    convert(10'd0,    2,  1'b0); // R5 minimum settle
    convert(10'd1023, 2,  1'b0); // R5 R6 full scale
    convert(10'd512,  3,  1'b0);
    convert(10'd511,  4,  1'b0);
    convert(10'd341,  7,  1'b1); // R7 extra start
    convert(10'd682,  5,  1'b0);
    convert(10'd1,    2,  1'b0);
    convert(10'd777,  12, 1'b0);
    convert(10'd1022, 40, 1'b1); // R3 long settle, R7
    chk("R6 queue drained", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule